// File: doc/BRIEF.md
# Leaky-bucket memory error monitor

This block watches correctable and uncorrectable error reports coming from a memory controller and decides which of them deserve a log entry. Each DIMM slot has its own saturating counter of correctable errors. A correctable error is logged only when that slot's counter reaches the threshold chosen by the mode input. The threshold can be 20, 10 or 5 errors, every error, or no error at all. After a slot has crossed its threshold, further correctable errors on that slot are dropped.

A periodic leak tick lowers every nonzero counter by one. Errors that arrive slowly over a long runtime therefore drain away and never add up to a crossing. An uncorrectable error is always logged at once. It also lights its slot's fault LED and latches the system status into solid amber.

Log events come out as a registered one-cycle pulse that carries the slot and the kind of error. The fault LEDs and the amber status stay set until a synchronous clear input or reset zeroes all state.

Top module: `ecc_leak_monitor`

## Requirements
- R1: Mode codes 0, 1 and 2 select thresholds of 20, 10 and 5. A correctable error on a slot produces a log event only when it brings that slot's count to the threshold, and that event lights the slot's fault LED.
- R2: Once a slot has crossed its numeric threshold, later correctable errors on that slot produce no log event and are not counted, even after leak ticks, until a clear.
- R3: In mode 3, every correctable error produces a log event of the correctable kind and lights the slot's LED. Fault LEDs only ever turn on until a clear.
- R4: Mode 4, and the unused codes 5 to 7, count correctable errors but never log them and never light an LED. The count carries over when the mode later changes to a numeric threshold.
- R5: Each leak tick lowers every nonzero slot count by one. A count of zero stays at zero.
- R6: When a leak tick and an accepted correctable error hit the same slot in the same cycle, the slot's count stays unchanged. This also holds at zero.
- R7: Slot counts are 5 bits wide and saturate at 31 rather than wrapping.
- R8: An uncorrectable error produces a log event of kind 1 for its slot and lights that slot's LED. It also sets the amber status, which stays set until a clear. A correctable strobe in the same cycle is dropped and not counted.
- R9: A log event appears on the outputs exactly one clock after the strobe that caused it, and lasts one cycle. Kind 0 means correctable and kind 1 means uncorrectable.
- R10: The synchronous clear zeroes all counts, crossed flags, LEDs, the amber status and any pending event. After a clear, a slot needs its full threshold again to cross.
- R11: After reset, no event is pending, all LEDs are off and the amber status is off.
- R12: Errors and counts on one slot do not affect any other slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_i | input | 1 | Synchronous clear of all monitor state |
| ce_i | input | 1 | Correctable error strobe, one per cycle |
| ue_i | input | 1 | Uncorrectable error strobe |
| slot_i | input | 3 | Slot that the current strobe refers to |
| mode_i | input | 3 | Threshold mode: 0=20, 1=10, 2=5, 3=all, 4..7=none |
| leak_i | input | 1 | Leak tick, decays every count by one |
| evt_valid_o | output | 1 | One-cycle log event pulse |
| evt_kind_o | output | 1 | Event kind: 0 correctable, 1 uncorrectable |
| evt_slot_o | output | 3 | Slot of the logged event |
| led_o | output | 8 | Per-slot fault LEDs, sticky until clear |
| status_amber_o | output | 1 | Solid amber system status, sticky until clear |

## Verification
The assertions assume that every strobe refers to one slot per cycle and that slot_i only carries values that name a real slot. They also assume that mode_i holds still during the cycle a strobe is sampled. The directed stimulus changes the mode only between strobes and drives a single slot per cycle. Clear, leak and the strobes are driven on the falling edge, so each request is seen by exactly one rising edge.

// File: rtl/elm_pkg.sv
package elm_pkg;

    typedef enum logic [2:0] {
        MODE_T20  = 3'd0,
        MODE_T10  = 3'd1,
        MODE_T5   = 3'd2,
        MODE_ALL  = 3'd3,
        MODE_NONE = 3'd4
    } thr_mode_e;

    typedef enum logic {
        EVT_CORR   = 1'b0,
        EVT_UNCORR = 1'b1
    } evt_kind_e;

    localparam int LIMIT_W = 8;

    typedef struct packed {
        logic               numeric;
        logic               log_all;
        logic [LIMIT_W-1:0] limit;
    } thr_policy_t;

    function automatic thr_policy_t mode_policy(input logic [2:0] code);
        thr_policy_t p;
        p.numeric = 1'b0;
        p.log_all = 1'b0;
        p.limit   = '0;
        case (code)
            MODE_T20: begin p.numeric = 1'b1; p.limit = 8'd20; end
            MODE_T10: begin p.numeric = 1'b1; p.limit = 8'd10; end
            MODE_T5:  begin p.numeric = 1'b1; p.limit = 8'd5;  end
            MODE_ALL: begin p.log_all = 1'b1; end
            default:  begin end
        endcase
        return p;
    endfunction

endpackage

// File: rtl/elm_slot_cell.sv
module elm_slot_cell
    import elm_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        hit_ce,
    input  logic        hit_ue,
    input  logic        leak,
    input  thr_policy_t policy,
    output logic        fire_ce,
    output logic        led
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             crossed_q, crossed_d;
    logic             led_q, led_d;
    logic             accept;
    logic             reach;

    assign accept = hit_ce && !crossed_q;

    always_comb begin
        if (accept && leak)
            cnt_d = cnt_q;
        else if (accept)
            cnt_d = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;
        else if (leak && (cnt_q != '0))
            cnt_d = cnt_q - 1'b1;
        else
            cnt_d = cnt_q;
    end

    assign reach   = (LIMIT_W'(cnt_d) >= policy.limit);
    assign fire_ce = accept && (policy.log_all || (policy.numeric && reach));

    always_comb begin
        crossed_d = crossed_q | (accept && policy.numeric && reach);
        led_d     = led_q | fire_ce | hit_ue;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q     <= '0;
            crossed_q <= 1'b0;
            led_q     <= 1'b0;
        end else begin
            cnt_q     <= cnt_d;
            crossed_q <= crossed_d;
            led_q     <= led_d;
        end
    end

    assign led = led_q;

endmodule

// File: rtl/elm_event_reg.sv
module elm_event_reg
    import elm_pkg::*;
#(
    parameter int SLOT_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              ue_req,
    input  logic              ce_fire,
    input  logic [SLOT_W-1:0] slot,
    output logic              evt_valid,
    output evt_kind_e         evt_kind,
    output logic [SLOT_W-1:0] evt_slot,
    output logic              amber
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            evt_valid <= 1'b0;
            evt_kind  <= EVT_CORR;
            evt_slot  <= '0;
            amber     <= 1'b0;
        end else begin
            evt_valid <= ue_req || ce_fire;
            evt_kind  <= ue_req ? EVT_UNCORR : EVT_CORR;
            evt_slot  <= slot;
            amber     <= amber | ue_req;
        end
    end

endmodule

// File: rtl/ecc_leak_monitor.sv
module ecc_leak_monitor
    import elm_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    parameter int CNT_W     = 5
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clr_i,
    input  logic                         ce_i,
    input  logic                         ue_i,
    input  logic [$clog2(NUM_SLOTS)-1:0] slot_i,
    input  logic [2:0]                   mode_i,
    input  logic                         leak_i,
    output logic                         evt_valid_o,
    output logic                         evt_kind_o,
    output logic [$clog2(NUM_SLOTS)-1:0] evt_slot_o,
    output logic [NUM_SLOTS-1:0]         led_o,
    output logic                         status_amber_o
);
    localparam int SLOT_W = $clog2(NUM_SLOTS);

    thr_policy_t          policy;
    logic                 ce_req;
    logic [NUM_SLOTS-1:0] sel;
    logic [NUM_SLOTS-1:0] fire_vec;
    evt_kind_e            kind;

    assign policy = mode_policy(mode_i);
    assign ce_req = ce_i && !ue_i;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        assign sel[g] = (slot_i == SLOT_W'(g));

        elm_slot_cell #(.CNT_W(CNT_W)) u_cell (
            .clk     (clk),
            .rst     (rst),
            .clr     (clr_i),
            .hit_ce  (ce_req && sel[g]),
            .hit_ue  (ue_i && sel[g]),
            .leak    (leak_i),
            .policy  (policy),
            .fire_ce (fire_vec[g]),
            .led     (led_o[g])
        );
    end

    elm_event_reg #(.SLOT_W(SLOT_W)) u_evt (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr_i),
        .ue_req    (ue_i),
        .ce_fire   (|fire_vec),
        .slot      (slot_i),
        .evt_valid (evt_valid_o),
        .evt_kind  (kind),
        .evt_slot  (evt_slot_o),
        .amber     (status_amber_o)
    );

    assign evt_kind_o = kind;

endmodule

// File: rtl/elm_checker.sv
module elm_checker #(
    parameter int NUM_SLOTS = 8,
    parameter int SLOT_W    = 3
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 clr_i,
    input logic                 ce_i,
    input logic                 ue_i,
    input logic [SLOT_W-1:0]    slot_i,
    input logic [2:0]           mode_i,
    input logic                 evt_valid_o,
    input logic                 evt_kind_o,
    input logic [SLOT_W-1:0]    evt_slot_o,
    input logic [NUM_SLOTS-1:0] led_o,
    input logic                 status_amber_o
);
    a_r9_event_has_cause: assert property (@(posedge clk) disable iff (rst)
        evt_valid_o |-> $past(ce_i || ue_i));

    a_r8_ue_logged: assert property (@(posedge clk) disable iff (rst)
        (ue_i && !clr_i) |=> (evt_valid_o && evt_kind_o && evt_slot_o == $past(slot_i)
                              && status_amber_o && ((led_o >> $past(slot_i)) & 1) != 0));

    a_r8_amber_sticky: assert property (@(posedge clk) disable iff (rst)
        (status_amber_o && !clr_i) |=> status_amber_o);

    a_r3_led_sticky: assert property (@(posedge clk) disable iff (rst)
        !clr_i |=> ((led_o & $past(led_o)) == $past(led_o)));

    a_r4_none_silent: assert property (@(posedge clk) disable iff (rst)
        (ce_i && !ue_i && mode_i >= 3'd4) |=> !evt_valid_o);

    a_r1_event_lights_led: assert property (@(posedge clk) disable iff (rst)
        evt_valid_o |-> (((led_o >> evt_slot_o) & 1) != 0));

    a_r10_clear_all: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (led_o == '0 && !status_amber_o && !evt_valid_o));

endmodule

bind ecc_leak_monitor elm_checker #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .clr_i          (clr_i),
    .ce_i           (ce_i),
    .ue_i           (ue_i),
    .slot_i         (slot_i),
    .mode_i         (mode_i),
    .evt_valid_o    (evt_valid_o),
    .evt_kind_o     (evt_kind_o),
    .evt_slot_o     (evt_slot_o),
    .led_o          (led_o),
    .status_amber_o (status_amber_o)
);

// File: tb/ecc_leak_monitor_bench.sv
module ecc_leak_monitor_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       clr_i = 1'b0, ce_i = 1'b0, ue_i = 1'b0, leak_i = 1'b0;
    logic [2:0] slot_i = '0, mode_i = '0;
    logic       evt_valid_o, evt_kind_o, status_amber_o;
    logic [2:0] evt_slot_o;
    logic [7:0] led_o;
    int checks = 0, fails = 0;

    always #10 clk = ~clk;

    ecc_leak_monitor u_ecc_leak_monitor (
        .clk(clk), .rst(rst), .clr_i(clr_i), .ce_i(ce_i), .ue_i(ue_i),
        .slot_i(slot_i), .mode_i(mode_i), .leak_i(leak_i),
        .evt_valid_o(evt_valid_o), .evt_kind_o(evt_kind_o), .evt_slot_o(evt_slot_o),
        .led_o(led_o), .status_amber_o(status_amber_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input logic ce, input logic ue, input logic lk, input logic cl,
                        input logic [2:0] s);
        @(negedge clk);
        ce_i = ce; ue_i = ue; leak_i = lk; clr_i = cl; slot_i = s;
        @(negedge clk);
        ce_i = 1'b0; ue_i = 1'b0; leak_i = 1'b0; clr_i = 1'b0;
    endtask

    task automatic do_clear();
        step(1'b0, 1'b0, 1'b0, 1'b1, 3'd0);
    endtask

    task automatic leak_n(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b1, 1'b0, 3'd0);
    endtask

    task automatic ce_expect(input logic [2:0] s, input logic exp_evt, input string req);
        step(1'b1, 1'b0, 1'b0, 1'b0, s);
        check(req, evt_valid_o, exp_evt);
        if (exp_evt) begin
            check(req, evt_kind_o, 1'b0);
            check(req, evt_slot_o, s);
        end
    endtask

    task automatic t_reset();
        check("R11 evt", evt_valid_o, 1'b0);
        check("R11 led", led_o, 8'h00);
        check("R11 amber", status_amber_o, 1'b0);
    endtask

    task automatic t_numeric(input logic [2:0] m, input int thr);
        do_clear();
        mode_i = m;
        for (int i = 1; i <= thr; i++) ce_expect(3'd2, i == thr, "R1 threshold");
        check("R1 led", led_o, 8'h04);
        ce_expect(3'd2, 1'b0, "R2 after crossing");
        leak_n(thr);
        ce_expect(3'd2, 1'b0, "R2 after leak");
    endtask

    task automatic t_all();
        do_clear();
        mode_i = 3'd3;
        for (int i = 0; i < 3; i++) ce_expect(3'd5, 1'b1, "R3 all mode");
        check("R3 led", led_o, 8'h20);
    endtask

    task automatic t_none();
        do_clear();
        mode_i = 3'd4;
        for (int i = 0; i < 4; i++) ce_expect(3'd1, 1'b0, "R4 none mode");
        check("R4 no led", led_o, 8'h00);
        mode_i = 3'd2;
        ce_expect(3'd1, 1'b1, "R4 count carried");
        do_clear();
        mode_i = 3'd7;
        ce_expect(3'd1, 1'b0, "R4 code 7");
        check("R4 code 7 led", led_o, 8'h00);
    endtask

    task automatic t_leak();
        do_clear();
        mode_i = 3'd2;
        for (int i = 0; i < 3; i++) ce_expect(3'd0, 1'b0, "R5 fill");
        leak_n(5);
        for (int i = 0; i < 4; i++) ce_expect(3'd0, 1'b0, "R5 after decay");
        ce_expect(3'd0, 1'b1, "R5 floor at zero");
    endtask

    task automatic t_cancel();
        do_clear();
        mode_i = 3'd2;
        for (int i = 0; i < 4; i++) ce_expect(3'd6, 1'b0, "R6 fill");
        step(1'b1, 1'b0, 1'b1, 1'b0, 3'd6);
        check("R6 cancel no event", evt_valid_o, 1'b0);
        ce_expect(3'd6, 1'b1, "R6 count held at 4");
        do_clear();
        step(1'b1, 1'b0, 1'b1, 1'b0, 3'd6);
        check("R6 cancel at zero", evt_valid_o, 1'b0);
        for (int i = 0; i < 4; i++) ce_expect(3'd6, 1'b0, "R6 zero held");
        ce_expect(3'd6, 1'b1, "R6 zero held cross");
    endtask

    task automatic t_saturate();
        do_clear();
        mode_i = 3'd4;
        for (int i = 0; i < 40; i++) ce_expect(3'd4, 1'b0, "R7 fill");
        leak_n(12);
        mode_i = 3'd0;
        ce_expect(3'd4, 1'b1, "R7 saturated at 31");
    endtask

    task automatic t_uncorr();
        do_clear();
        mode_i = 3'd2;
        step(1'b0, 1'b1, 1'b0, 1'b0, 3'd7);
        check("R8 ue event", evt_valid_o, 1'b1);
        check("R8 ue kind", evt_kind_o, 1'b1);
        check("R8 ue slot", evt_slot_o, 3'd7);
        check("R8 ue led", led_o, 8'h80);
        check("R8 amber", status_amber_o, 1'b1);
        @(negedge clk);
        check("R9 one-cycle pulse", evt_valid_o, 1'b0);
        check("R8 amber held", status_amber_o, 1'b1);
        for (int i = 0; i < 4; i++) ce_expect(3'd3, 1'b0, "R8 fill");
        step(1'b1, 1'b1, 1'b0, 1'b0, 3'd3);
        check("R8 priority kind", evt_kind_o, 1'b1);
        check("R8 priority slot", evt_slot_o, 3'd3);
        ce_expect(3'd3, 1'b1, "R8 dropped ce not counted");
    endtask

    task automatic t_indep();
        do_clear();
        mode_i = 3'd2;
        for (int i = 0; i < 4; i++) ce_expect(3'd0, 1'b0, "R12 slot0");
        for (int i = 0; i < 4; i++) ce_expect(3'd1, 1'b0, "R12 slot1");
        ce_expect(3'd0, 1'b1, "R12 slot0 cross");
        check("R12 led", led_o, 8'h01);
    endtask

    task automatic t_clear();
        do_clear();
        mode_i = 3'd2;
        for (int i = 0; i < 5; i++) ce_expect(3'd2, i == 4, "R10 first cross");
        step(1'b0, 1'b1, 1'b0, 1'b0, 3'd5);
        do_clear();
        check("R10 led", led_o, 8'h00);
        check("R10 amber", status_amber_o, 1'b0);
        check("R10 evt", evt_valid_o, 1'b0);
        for (int i = 0; i < 5; i++) ce_expect(3'd2, i == 4, "R10 recount");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_numeric(3'd0, 20);
        t_numeric(3'd1, 10);
        t_numeric(3'd2, 5);
        t_all();
        t_none();
        t_leak();
        t_cancel();
        t_saturate();
        t_uncorr();
        t_indep();
        t_clear();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule